// File: doc/BRIEF.md
# Dual-Unit Randomized Transmit Selector

Two network output units share every operation the processor issues, but only one of them may carry a given connection attempt. This block holds the control for both units. On each attempt every unit XORs two shared random bits and compares the result with its own unit number. The unit that matches owns the attempt, and the other unit waits. The link protocol itself stays outside the block. The owning unit only learns from two inputs when its attempt has finished and whether it failed.

When an attempt fails, the owner writes a two-word record to memory: a status word whose bit 0 flags the failure, and a bad-checksum word. If retries remain, the owner then raises a one-cycle retransmit request. On the next cycle both units draw the random bits again and both step their retry counters, so the two units always agree on how many retries are left. When an attempt fails with the retry budget already spent, the owner stops and shows a give-up flag instead. A successful attempt writes only the status word and raises a done flag. Record addresses start at the status pointer and move up by one double word per retransmission.

Top module: `dual_tx_select`

## Requirements
- R1: On an issue cycle, unit u (u = 0 or 1) becomes the owner and drives its `active` bit from the next cycle exactly when `rnd_a ^ rnd_b == u`. At most one `active` bit is ever set.
- R2: An `att_done` or `att_fail` pulse to a unit that does not own the attempt has no effect: no memory write, no retransmit request, no change of owner.
- R3: In the cycle after the owner sees `att_done` with `att_fail`, and only when its retry count is below `max_retries`, the owner raises its `retx` bit for exactly one cycle. The other unit's bit stays low.
- R4: At the clock edge that ends a `retx` cycle, both units select a new owner from `rnd_a ^ rnd_b` and both add one to their retry counts, so the two counts stay equal.
- R5: A failure seen while the retry count equals `max_retries` raises no `retx`. It sets `gave_up`, and no unit stays active.
- R6: Each unit's record address is `status_ptr` for the first attempt after an issue and goes up by 1 (one double word) at every retransmission.
- R7: For a failed attempt, in the cycle after `att_done` the owner drives both word enables (`mem_wen` pair = 2'b11). The low word of its data is the attempt status with bit 0 forced to 1. The high word is the bad-checksum input.
- R8: For a successful attempt, in the cycle after `att_done` the owner drives only the low word enable (2'b01), with status bit 0 forced to 0, and `op_done` goes high while `busy` goes low.
- R9: An issue clears both retry counts to 0, reloads the record address from `status_ptr`, and clears a previous give-up or done state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Network clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | New operation, seen by both units |
| rnd_a | input | 1 | First shared random bit |
| rnd_b | input | 1 | Second shared random bit |
| status_ptr | input | ADDR_W | Double-word address of the first status record |
| max_retries | input | RETRY_W | Number of retransmissions allowed |
| att_done | input | 2 | Per unit: attempt finished |
| att_fail | input | 2 | Per unit: finished attempt failed |
| att_status | input | 2*DATA_W | Per unit: raw status word from the link |
| att_badck | input | 2*DATA_W | Per unit: bad-checksum word from the link |
| active | output | 2 | Per unit: owns the current attempt |
| retx | output | 2 | Per unit: retransmit request |
| busy | output | 1 | An attempt or retransmit is in progress |
| op_done | output | 1 | The operation finished successfully |
| gave_up | output | 1 | Retries exhausted |
| retry_cnt | output | 2*RETRY_W | Per unit: retries used so far |
| mem_wen | output | 4 | Per unit: word enables {high, low} |
| mem_addr | output | 2*ADDR_W | Per unit: record double-word address |
| mem_data | output | 4*DATA_W | Per unit: {bad-checksum word, status word} |

## Verification
The bench builds the block with a 3-bit retry count and a 12-bit record address, keeping the 32-bit data words. With those widths, small retry budgets of one to three can be reached in a few cycles. Those budgets cover both paths: a retry chain that ends in success, and one that runs out and gives up.

All four random-bit combinations are driven at issue. Fresh combinations are also driven at each retransmit, so ownership can move to the other unit or stay with the same one. Checking the record addresses written over successive failures shows that the two units keep the same count across a change of owner.

// File: rtl/dtx_pkg.sv
package dtx_pkg;

  typedef enum logic [2:0] {
    U_IDLE   = 3'd0,
    U_WAIT   = 3'd1,
    U_ACTIVE = 3'd2,
    U_RETX   = 3'd3,
    U_DONE   = 3'd4,
    U_GIVEUP = 3'd5
  } ustate_e;

  localparam int NUM_UNITS = 2;

  // ownership rule: xor of the shared random bits names the unit
  function automatic logic owns_attempt(input logic a, input logic b, input logic id);
    return (a ^ b) == id;
  endfunction

  // word enables for a finished attempt: failures carry both words
  function automatic logic [1:0] rec_enables(input logic failed);
    return failed ? 2'b11 : 2'b01;
  endfunction

endpackage

// File: rtl/dtx_pick.sv
module dtx_pick
  import dtx_pkg::*;
#(
  parameter int UNIT_ID = 0
) (
  input  logic rnd_a,
  input  logic rnd_b,
  output logic hit
);
  localparam logic ID_BIT = UNIT_ID[0];

  always_comb hit = owns_attempt(rnd_a, rnd_b, ID_BIT);
endmodule

// File: rtl/dtx_unit.sv
module dtx_unit
  import dtx_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int RETRY_W = 4,
  parameter int UNIT_ID = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issue,
  input  logic                rnd_a,
  input  logic                rnd_b,
  input  logic                retx_in,
  input  logic [ADDR_W-1:0]   status_ptr,
  input  logic [RETRY_W-1:0]  max_retries,
  input  logic                att_done,
  input  logic                att_fail,
  input  logic [DATA_W-1:0]   att_status,
  input  logic [DATA_W-1:0]   att_badck,
  output logic                active,
  output logic                retx_o,
  output logic                done_o,
  output logic                giveup_o,
  output logic [RETRY_W-1:0]  retry_cnt,
  output logic [1:0]          mem_wen,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [2*DATA_W-1:0] mem_data
);
  localparam int REC_W = 2 * DATA_W;

  function automatic logic [DATA_W-1:0] stamp_status(input logic [DATA_W-1:0] raw,
                                                      input logic failed);
    return {raw[DATA_W-1:1], failed};
  endfunction

  function automatic logic [ADDR_W-1:0] next_slot(input logic [ADDR_W-1:0] cur);
    return cur + ADDR_W'(1);
  endfunction

  ustate_e            st;
  logic               hit;
  logic [RETRY_W-1:0] cnt;
  logic [ADDR_W-1:0]  wr_ptr;
  logic               retx_q;
  logic [1:0]         wen_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [REC_W-1:0]   data_q;

  // named internal events
  logic ev_launch, ev_resel, ev_fin, exhausted;

  dtx_pick #(.UNIT_ID(UNIT_ID)) u_pick (
    .rnd_a (rnd_a),
    .rnd_b (rnd_b),
    .hit   (hit)
  );

  always_comb begin
    ev_launch = issue;
    ev_resel  = retx_in & ~issue;
    ev_fin    = (st == U_ACTIVE) & att_done & ~issue & ~retx_in;
    exhausted = (cnt == max_retries);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= U_IDLE;
      cnt    <= '0;
      wr_ptr <= '0;
      retx_q <= 1'b0;
      wen_q  <= 2'b00;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      retx_q <= 1'b0;
      wen_q  <= 2'b00;
      if (ev_launch) begin
        cnt    <= '0;
        wr_ptr <= status_ptr;
        st     <= hit ? U_ACTIVE : U_WAIT;
      end else if (ev_resel) begin
        cnt    <= cnt + RETRY_W'(1);
        wr_ptr <= next_slot(wr_ptr);
        st     <= hit ? U_ACTIVE : U_WAIT;
      end else if (ev_fin) begin
        wen_q  <= rec_enables(att_fail);
        addr_q <= wr_ptr;
        data_q <= {att_badck, stamp_status(att_status, att_fail)};
        if (!att_fail) begin
          st <= U_DONE;
        end else if (exhausted) begin
          st <= U_GIVEUP;
        end else begin
          st     <= U_RETX;
          retx_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    active    = (st == U_ACTIVE);
    retx_o    = retx_q;
    done_o    = (st == U_DONE);
    giveup_o  = (st == U_GIVEUP);
    retry_cnt = cnt;
    mem_wen   = wen_q;
    mem_addr  = addr_q;
    mem_data  = data_q;
  end

  AST_RETX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    retx_o |=> !retx_o); // R3
  AST_RETX_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    retx_o |-> $past(active && att_done && att_fail)); // R3
  AST_RESEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resel |=> (retry_cnt == $past(retry_cnt) + RETRY_W'(1))); // R4
  AST_LAUNCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (retry_cnt == '0 && wr_ptr == $past(status_ptr))); // R9
  AST_FAIL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen != 2'b00) |-> (mem_data[0] == mem_wen[1])); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (retry_cnt <= max_retries)); // R5
endmodule

// File: rtl/dual_tx_select.sv
module dual_tx_select
  import dtx_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int RETRY_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    issue,
  input  logic                    rnd_a,
  input  logic                    rnd_b,
  input  logic [ADDR_W-1:0]       status_ptr,
  input  logic [RETRY_W-1:0]      max_retries,
  input  logic [1:0]              att_done,
  input  logic [1:0]              att_fail,
  input  logic [2*DATA_W-1:0]     att_status,
  input  logic [2*DATA_W-1:0]     att_badck,
  output logic [1:0]              active,
  output logic [1:0]              retx,
  output logic                    busy,
  output logic                    op_done,
  output logic                    gave_up,
  output logic [2*RETRY_W-1:0]    retry_cnt,
  output logic [3:0]              mem_wen,
  output logic [2*ADDR_W-1:0]     mem_addr,
  output logic [4*DATA_W-1:0]     mem_data
);
  localparam int REC_W = 2 * DATA_W;

  logic                retx_any;
  logic [NUM_UNITS-1:0] done_u, giveup_u;

  always_comb retx_any = |retx;

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    dtx_unit #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .RETRY_W(RETRY_W),
      .UNIT_ID(g)
    ) u_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (issue),
      .rnd_a      (rnd_a),
      .rnd_b      (rnd_b),
      .retx_in    (retx_any),
      .status_ptr (status_ptr),
      .max_retries(max_retries),
      .att_done   (att_done[g]),
      .att_fail   (att_fail[g]),
      .att_status (att_status[g*DATA_W +: DATA_W]),
      .att_badck  (att_badck[g*DATA_W +: DATA_W]),
      .active     (active[g]),
      .retx_o     (retx[g]),
      .done_o     (done_u[g]),
      .giveup_o   (giveup_u[g]),
      .retry_cnt  (retry_cnt[g*RETRY_W +: RETRY_W]),
      .mem_wen    (mem_wen[g*2 +: 2]),
      .mem_addr   (mem_addr[g*ADDR_W +: ADDR_W]),
      .mem_data   (mem_data[g*REC_W +: REC_W])
    );
  end

  always_comb begin
    busy    = |active | retx_any;
    op_done = |done_u;
    gave_up = |giveup_u;
  end

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(active)); // R1
  AST_CNT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    retry_cnt[RETRY_W-1:0] == retry_cnt[2*RETRY_W-1:RETRY_W]); // R4
  AST_ONE_RETX: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(retx)); // R3
  AST_GIVEUP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    gave_up |-> (active == 2'b00 && retx == 2'b00)); // R5
endmodule

// File: tb/dual_tx_select_tb.sv
module dual_tx_select_tb;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue = 1'b0, rnd_a = 1'b0, rnd_b = 1'b0;
  logic [AW-1:0] status_ptr = '0;
  logic [RW-1:0] max_retries = '0;
  logic [1:0] att_done = '0, att_fail = '0;
  logic [2*DW-1:0] att_status = '0, att_badck = '0;
  logic [1:0] active, retx;
  logic busy, op_done, gave_up;
  logic [2*RW-1:0] retry_cnt;
  logic [3:0] mem_wen;
  logic [2*AW-1:0] mem_addr;
  logic [4*DW-1:0] mem_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dual_tx_select #(.ADDR_W(AW), .DATA_W(DW), .RETRY_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .rnd_a(rnd_a), .rnd_b(rnd_b),
    .status_ptr(status_ptr), .max_retries(max_retries),
    .att_done(att_done), .att_fail(att_fail), .att_status(att_status),
    .att_badck(att_badck), .active(active), .retx(retx), .busy(busy),
    .op_done(op_done), .gave_up(gave_up), .retry_cnt(retry_cnt),
    .mem_wen(mem_wen), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic launch(input logic a, input logic b);
    rnd_a = a; rnd_b = b; issue = 1'b1;
    tick();
    issue = 1'b0;
  endtask

  task automatic attempt(input int u, input logic fl,
                         input logic [31:0] st, input logic [31:0] bd);
    att_done[u] = 1'b1; att_fail[u] = fl;
    att_status[u*DW +: DW] = st; att_badck[u*DW +: DW] = bd;
    tick();
    att_done = '0; att_fail = '0;
  endtask

  task automatic chk_rec(input string req, input int u, input logic fl,
                         input logic [AW-1:0] adr, input logic [31:0] st,
                         input logic [31:0] bd);
    logic [3:0] wexp;
    wexp = 4'((fl ? 2'b11 : 2'b01)) << (2*u);
    chk(req, "word enables", mem_wen, wexp);
    chk(req, "record address", mem_addr[u*AW +: AW], adr);
    chk(req, "status word", mem_data[u*64 +: 32], {st[31:1], fl});
    if (fl) chk(req, "bad checksum word", mem_data[u*64+32 +: 32], bd);
  endtask

  task automatic t_reset;
    chk("R1", "active after reset", active, 2'b00);
    chk("R3", "retx after reset", retx, 2'b00);
    chk("R9", "counts after reset", retry_cnt, '0);
    chk("R8", "no write after reset", mem_wen, 4'b0);
  endtask

  task automatic t_select;
    for (int i = 0; i < 4; i++) begin
      logic a, b;
      int o;
      a = i[1]; b = i[0];
      o = (a ^ b) ? 1 : 0;
      status_ptr = AW'(12'h010 + i);
      max_retries = 3'd2;
      launch(a, b);
      chk("R1", "owner from xor", active, 2'b01 << o);
      // R2: stimulus on the non-owner is ignored
      attempt(1 - o, 1'b1, 32'hDEAD_0001, 32'h1);
      chk("R2", "non-owner no write", mem_wen, 4'b0);
      chk("R2", "non-owner no retx", retx, 2'b00);
      chk("R2", "owner unchanged", active, 2'b01 << o);
      attempt(o, 1'b0, 32'hA5A5_0003 + i, 32'h0);
      chk_rec("R8", o, 1'b0, AW'(12'h010 + i), 32'hA5A5_0003 + i, 32'h0);
      chk("R8", "op_done", op_done, 1'b1);
      chk("R8", "busy low", busy, 1'b0);
    end
  endtask

  task automatic t_retry;
    status_ptr = 12'h100; max_retries = 3'd3;
    launch(1'b1, 1'b0);
    chk("R1", "owner 1", active, 2'b10);
    attempt(1, 1'b1, 32'h1234_5670, 32'hBAD0_0001);
    chk_rec("R7", 1, 1'b1, 12'h100, 32'h1234_5670, 32'hBAD0_0001);
    chk("R3", "retx from unit 1 only", retx, 2'b10);
    rnd_a = 1'b0; rnd_b = 1'b0;
    tick();
    chk("R3", "retx one cycle", retx, 2'b00);
    chk("R4", "reselect to unit 0", active, 2'b01);
    chk("R4", "both counts 1", retry_cnt, {3'd1, 3'd1});
    attempt(0, 1'b1, 32'h0000_F00F, 32'hBAD0_0002);
    chk_rec("R6", 0, 1'b1, 12'h101, 32'h0000_F00F, 32'hBAD0_0002);
    chk("R3", "retx from unit 0 only", retx, 2'b01);
    rnd_a = 1'b1; rnd_b = 1'b1;
    tick();
    chk("R4", "reselect stays unit 0", active, 2'b01);
    chk("R4", "both counts 2", retry_cnt, {3'd2, 3'd2});
    attempt(0, 1'b0, 32'h7777_7777, 32'h0);
    chk_rec("R6", 0, 1'b0, 12'h102, 32'h7777_7777, 32'h0);
    chk("R8", "done after retries", op_done, 1'b1);
    chk("R3", "no retx on success", retx, 2'b00);
  endtask

  task automatic t_giveup;
    status_ptr = 12'h200; max_retries = 3'd1;
    launch(1'b0, 1'b1);
    chk("R1", "owner 1", active, 2'b10);
    attempt(1, 1'b1, 32'h0000_0010, 32'hC0DE_0001);
    chk("R3", "retx with budget", retx, 2'b10);
    rnd_a = 1'b1; rnd_b = 1'b0;
    tick();
    chk("R4", "reselect unit 1", active, 2'b10);
    chk("R4", "counts 1", retry_cnt, {3'd1, 3'd1});
    attempt(1, 1'b1, 32'h0000_0020, 32'hC0DE_0002);
    chk_rec("R7", 1, 1'b1, 12'h201, 32'h0000_0020, 32'hC0DE_0002);
    chk("R5", "no retx when spent", retx, 2'b00);
    chk("R5", "gave_up", gave_up, 1'b1);
    chk("R5", "nobody active", active, 2'b00);
    tick();
    chk("R5", "still idle", {active, retx, mem_wen}, 8'h00);
    chk("R5", "give-up held", gave_up, 1'b1);
  endtask

  task automatic t_reissue;
    status_ptr = 12'h300; max_retries = 3'd2;
    launch(1'b0, 1'b0);
    chk("R9", "counts cleared", retry_cnt, '0);
    chk("R9", "give-up cleared", gave_up, 1'b0);
    chk("R9", "owner 0", active, 2'b01);
    attempt(0, 1'b0, 32'h0BAD_BEE1, 32'h0);
    chk_rec("R9", 0, 1'b0, 12'h300, 32'h0BAD_BEE1, 32'h0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_select();
    t_retry();
    t_giveup();
    t_reissue();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule